// File: doc/BRIEF.md
# Bus Clock Divider and Gating Controller

This power-management block derives a bus clock enable from the system clock and produces per-device clock enables. The bus rate is chosen by a 3-bit code. Codes 0 to 6 divide the system clock by a power of two from 2 to 128. Code 7 bypasses the divider. A mode bit selects fast-bus operation, which uses the divided bus clock, or standard-bus operation, in which the bus runs at the system clock rate. The block does not drive a real clock. It drives an enable strobe that is high for one system cycle per bus period.

Changing the bus rate is only safe while the bus is idle. A newly written code is therefore held pending and applied at the first clock edge where the bus-idle input is high. At that edge the divider counter restarts, so the first period at the new rate is complete. There are two 16-bit device clock masks. The run-mode mask applies while the power-state input is low. The power-down mask applies while it is high. A mask bit of 1 enables a device clock and 0 gates it. Software reaches the control register and both masks through a small word-offset register port.

Top module: `busclk_gate_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x0008: divider code 0, so divide-by-2, and fast-bus mode 1. Both mask registers read 0xFFFF.
- R2: In fast-bus mode with an applied code c from 0 to 6, `bclk_en` is high for exactly one cycle in every 2^(c+1) cycles.
- R3: In fast-bus mode with an applied code of 7, `bclk_en` is high in every cycle.
- R4: A code written to control bits [2:0] is held pending and does not change the bus rate while `bus_idle` is low. It is applied at the first rising edge where it is pending and `bus_idle` is high. The counter restarts at that edge, and the first pulse at the new rate comes in the 2^(c+1)-th cycle after it.
- R5: Control bit 3 is the bus mode: 1 is fast-bus and 0 is standard-bus. It takes effect at the write edge, without waiting for bus idle. In standard-bus mode `bclk_en` is high every cycle. `fast_bus` shows the bit.
- R6: `reg_addr` is a byte offset. 0x4 is the control register, 0x8 is the run-mode mask and 0xC is the power-down mask. A write happens on a rising edge while `reg_wr` is high. `reg_rdata` shows the addressed register combinationally. Unmapped offsets read 0, and writes to them change nothing.
- R7: `dev_clk_en` is taken from the run-mode mask while `pwr_down` is low and from the power-down mask while it is high. A bit value of 1 enables the clock. Bit 0 is the external bus clock output, bit 7 is SRAM, bit 8 is the test controller, bit 9 is DMA, bit 10 is the DRAM controller, bit 11 is the bus controller and bit 12 is the peripheral-bus bridge.
- R8: Reserved mask bits 6:1 and 15:13 read back as written, but the matching `dev_clk_en` bits are always 0.
- R9: Control bits [2:0] read back the most recently written code, even while that code is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| bus_idle | input | 1 | High when the bus has no transfer in flight |
| pwr_down | input | 1 | Power state: 0 is run, 1 is power-down |
| bclk_en | output | 1 | Bus clock enable strobe |
| fast_bus | output | 1 | Current bus mode (1 is fast-bus) |
| dev_clk_en | output | 16 | Gated per-device clock enables |

## Verification
The bench holds `bus_idle` low across a code write. A design that applies the code at once would change the pulse spacing early, and one that ignores the idle edge would never change it. Right after each idle edge it checks the position of the first pulse. A design that does not restart the counter would give a short first period at the new rate. It writes a new code while the old one is still pending, which shows whether the latest value wins. It also writes all-ones to the reserved mask bits and flips the power state, which catches a design that leaks reserved bits to the outputs or selects the wrong mask.

// File: rtl/busclk_pkg.sv
// Package: shared constants of the bus clock divider and gating controller.
// Assumes byte offsets on a 4-bit address and 16-bit register data.
package busclk_pkg;
    localparam int BC_DATA_W = 16;
    localparam int BC_ADDR_W = 4;
    localparam int BC_CODE_W = 3;

    localparam logic [BC_ADDR_W-1:0] OFS_CTRL = 4'h4;
    localparam logic [BC_ADDR_W-1:0] OFS_RUN  = 4'h8;
    localparam logic [BC_ADDR_W-1:0] OFS_PD   = 4'hC;

    // Device enable bits that are wired to a device; all others are reserved.
    localparam logic [BC_DATA_W-1:0] DEV_USED_MASK = 16'h1F81;

    // Control register fields.
    typedef struct packed {
        logic                 fast;
        logic [BC_CODE_W-1:0] code;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{fast: 1'b1, code: '0};
endpackage

// File: rtl/busclk_regs.sv
// Module: register file holding the control word and the two mask registers.
// Assumes a single-cycle write strobe; reads are combinational on the address.
// Emits a one-cycle strobe when the control word is written.
module busclk_regs
    import busclk_pkg::*;
#(
    parameter int DATA_W = BC_DATA_W,
    parameter int ADDR_W = BC_ADDR_W,
    parameter int CODE_W = BC_CODE_W
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CODE_W-1:0] prog_code,
    output logic              ctrl_wr,
    output logic              fast_mode,
    output logic [DATA_W-1:0] run_mask,
    output logic [DATA_W-1:0] pd_mask
);
    localparam int CTRL_W = CODE_W + 1;

    logic [CODE_W-1:0] code_q;
    logic              fast_q;
    logic [DATA_W-1:0] run_q;
    logic [DATA_W-1:0] pd_q;
    logic              hit_ctrl, hit_run, hit_pd;

    // Decode which register the current offset addresses.
    always_comb begin
        hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
        hit_run  = (reg_addr == ADDR_W'(OFS_RUN));
        hit_pd   = (reg_addr == ADDR_W'(OFS_PD));
    end

    // Register writes and reset values.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            code_q <= '0;
            fast_q <= 1'b1;
            run_q  <= '1;
            pd_q   <= '1;
        end else if (reg_wr) begin
            if (hit_ctrl) begin
                code_q <= reg_wdata[CODE_W-1:0];
                fast_q <= reg_wdata[CODE_W];
            end
            if (hit_run) run_q <= reg_wdata;
            if (hit_pd)  pd_q  <= reg_wdata;
        end
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl)     reg_rdata = DATA_W'({fast_q, code_q});
        else if (hit_run) reg_rdata = run_q;
        else if (hit_pd)  reg_rdata = pd_q;
    end

    assign prog_code = code_q;
    assign fast_mode = fast_q;
    assign run_mask  = run_q;
    assign pd_mask   = pd_q;
    assign ctrl_wr   = reg_wr && hit_ctrl;

    // R6
    unmapped_wr_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (reg_wr && !hit_ctrl && !hit_run && !hit_pd) |=>
            ($stable(run_q) && $stable(pd_q) && $stable(code_q) && $stable(fast_q)));

    // R9
    code_readback_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (reg_wr && hit_ctrl) |=> (code_q == $past(reg_wdata[CODE_W-1:0])));

    localparam int UNUSED_W = CTRL_W;
    logic [UNUSED_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/busclk_divider.sv
// Module: power-of-two bus clock divider with a deferred code update.
// Codes 0..(2^CODE_W-2) divide by 2^(code+1); the all-ones code bypasses.
// A written code waits until bus_idle is high. At that edge the counter
// restarts from zero, so the first new period is whole.
module busclk_divider #(
    parameter int CODE_W = 3
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] prog_code,
    input  logic              ctrl_wr,
    input  logic              bus_idle,
    input  logic              fast_mode,
    output logic              bclk_en
);
    localparam int                NUM_CODES = 1 << CODE_W;
    localparam int                CNT_W     = NUM_CODES - 1;
    localparam logic [CODE_W-1:0] BYPASS    = CODE_W'(NUM_CODES - 1);

    logic [CODE_W-1:0] active_q;
    logic              pend_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W:0]    period;
    logic [CNT_W-1:0]  limit;
    logic              apply;
    logic              wrap;

    // Terminal count for the applied code: period minus one.
    always_comb begin
        period = (CNT_W+1)'(1) << (int'(active_q) + 1);
        limit  = period[CNT_W-1:0] - CNT_W'(1);
        wrap   = (cnt_q == limit);
        apply  = pend_q && bus_idle;
    end

    // Pending flag and the applied divider code.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            active_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (apply) active_q <= prog_code;
            if (ctrl_wr)    pend_q <= 1'b1;
            else if (apply) pend_q <= 1'b0;
        end
    end

    // Free-running period counter, restarted when a new code is applied.
    always_ff @(posedge clk_sys) begin
        if (!rst_n)     cnt_q <= '0;
        else if (apply) cnt_q <= '0;
        else if (wrap)  cnt_q <= '0;
        else            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Strobe: every cycle in standard mode or bypass, else at terminal count.
    always_comb begin
        bclk_en = !fast_mode || (active_q == BYPASS) || wrap;
    end

    // R4
    hold_pending_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (pend_q && !bus_idle) |=> ($stable(active_q) && pend_q));

    // R4
    restart_on_apply_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (apply && !ctrl_wr) |=> (cnt_q == '0 && !pend_q && active_q == $past(prog_code)));

    // R2
    cnt_in_range_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (active_q != BYPASS) |-> (cnt_q <= limit));
endmodule

// File: rtl/busclk_gate.sv
// Module: selects the run or power-down mask and clears reserved bits.
// Assumes pwr_down is synchronous to clk_sys; the output is combinational.
module busclk_gate
    import busclk_pkg::*;
#(
    parameter int                 DATA_W   = BC_DATA_W,
    parameter logic [DATA_W-1:0]  USED_MSK = DEV_USED_MASK
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic [DATA_W-1:0] run_mask,
    input  logic [DATA_W-1:0] pd_mask,
    output logic [DATA_W-1:0] dev_clk_en
);
    logic [DATA_W-1:0] sel_mask;

    // Pick the mask for the power state.
    always_comb begin
        sel_mask = pwr_down ? pd_mask : run_mask;
    end

    // Per bit: wired device bits follow the mask, reserved bits are tied low.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (USED_MSK[b]) begin : g_used
            assign dev_clk_en[b] = sel_mask[b];
        end else begin : g_rsvd
            assign dev_clk_en[b] = 1'b0;
        end
    end

    // R8
    rsvd_low_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (dev_clk_en & ~USED_MSK) == '0);

    // R7
    run_hold_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (!pwr_down && $past(!pwr_down) && $stable(run_mask)) |-> $stable(dev_clk_en));
endmodule

// File: rtl/busclk_gate_ctrl.sv
// Module: top of the bus clock divider and gating controller.
// Wires the register file, the deferred divider and the mask selector.
// Assumes all inputs are synchronous to clk_sys and the reset is active low.
module busclk_gate_ctrl
    import busclk_pkg::*;
#(
    parameter int DATA_W = BC_DATA_W,
    parameter int ADDR_W = BC_ADDR_W,
    parameter int CODE_W = BC_CODE_W
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_idle,
    input  logic              pwr_down,
    output logic              bclk_en,
    output logic              fast_bus,
    output logic [DATA_W-1:0] dev_clk_en
);
    logic [CODE_W-1:0] prog_code;
    logic              ctrl_wr;
    logic              fast_mode;
    logic [DATA_W-1:0] run_mask;
    logic [DATA_W-1:0] pd_mask;

    busclk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) regs_i (
        .clk_sys   (clk_sys),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .prog_code (prog_code),
        .ctrl_wr   (ctrl_wr),
        .fast_mode (fast_mode),
        .run_mask  (run_mask),
        .pd_mask   (pd_mask)
    );

    busclk_divider #(.CODE_W(CODE_W)) div_i (
        .clk_sys   (clk_sys),
        .rst_n     (rst_n),
        .prog_code (prog_code),
        .ctrl_wr   (ctrl_wr),
        .bus_idle  (bus_idle),
        .fast_mode (fast_mode),
        .bclk_en   (bclk_en)
    );

    busclk_gate #(.DATA_W(DATA_W), .USED_MSK(DATA_W'(DEV_USED_MASK))) gate_i (
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .run_mask   (run_mask),
        .pd_mask    (pd_mask),
        .dev_clk_en (dev_clk_en)
    );

    assign fast_bus = fast_mode;

    // R5
    mode_immediate_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL)) |=> (fast_bus == $past(reg_wdata[CODE_W])));

    // R5
    std_mode_strobe_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !fast_bus |-> bclk_en);
endmodule

// File: tb/busclk_gate_ctrl_tb.sv
// Bench: behavioural reference model compared with the design on every clock.
module busclk_gate_ctrl_tb_top;
    logic        clk_sys = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        bus_idle = 1'b1;
    logic        pwr_down = 1'b0;
    logic        bclk_en;
    logic        fast_bus;
    logic [15:0] dev_clk_en;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    int          m_prog, m_active, m_phase;
    bit          m_pend, m_fast, m_live;
    logic [15:0] m_run, m_pd;

    always #4 clk_sys = ~clk_sys;

    busclk_gate_ctrl dut_i (
        .clk_sys(clk_sys), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_idle(bus_idle),
        .pwr_down(pwr_down), .bclk_en(bclk_en), .fast_bus(fast_bus),
        .dev_clk_en(dev_clk_en)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        case (reg_addr)
            4'h4:    return {12'h0, m_fast, 3'(m_prog)};
            4'h8:    return m_run;
            4'hC:    return m_pd;
            default: return 16'h0;
        endcase
    endfunction

    // Advance the model at the edge, then compare at the falling edge.
    task automatic cyc();
        bit apply;
        int n;
        bit exp_b;
        string tb;
        string tr;
        @(posedge clk_sys);
        cycles++;
        if (!rst_n) begin
            m_prog = 0; m_active = 0; m_phase = 0; m_pend = 0; m_fast = 1;
            m_run = 16'hFFFF; m_pd = 16'hFFFF; m_live = 0;
        end else begin
            m_live = 1;
            apply = m_pend && bus_idle;
            if (apply) begin
                m_active = m_prog; m_phase = 0; m_pend = 0;
            end else begin
                m_phase++;
            end
            if (reg_wr) begin
                case (reg_addr)
                    4'h4: begin m_prog = int'(reg_wdata[2:0]); m_fast = reg_wdata[3]; m_pend = 1; end
                    4'h8: m_run = reg_wdata;
                    4'hC: m_pd = reg_wdata;
                    default: ;
                endcase
            end
        end
        @(negedge clk_sys);
        if (m_live) begin
            n = 1 << (m_active + 1);
            if (!m_fast)            begin exp_b = 1'b1; tb = "R5 bclk_en standard mode"; end
            else if (m_active == 7) begin exp_b = 1'b1; tb = "R3 bclk_en bypass"; end
            else begin
                exp_b = ((m_phase % n) == n - 1);
                tb = (m_phase < n) ? "R4 bclk_en first period after apply" : "R2 bclk_en divided";
            end
            check(tb, 16'(bclk_en), 16'(exp_b));
            check("R5 fast_bus", 16'(fast_bus), 16'(m_fast));
            check("R7 dev_clk_en mask select",  dev_clk_en,
                  (pwr_down ? m_pd : m_run) & 16'h1F81);
            case (reg_addr)
                4'h4:       tr = "R9 ctrl readback";
                4'h8, 4'hC: tr = "R8 mask readback";
                default:    tr = "R6 unmapped read";
            endcase
            check(tr, reg_rdata, exp_rdata());
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk_sys);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        // R1 reset values through the register port
        reg_addr = 4'h4; cyc(); check("R1 ctrl reset", reg_rdata, 16'h0008);
        reg_addr = 4'h8; cyc(); check("R1 run mask reset", reg_rdata, 16'hFFFF);
        reg_addr = 4'hC; cyc(); check("R1 pd mask reset", reg_rdata, 16'hFFFF);
        run(8);
        // R2 every divided code in fast mode, applied while idle
        for (int c = 0; c < 7; c++) begin
            wr(4'h4, 16'(8 + c));
            run(2 * (1 << (c + 1)) + 3);
        end
        // R3 bypass code
        wr(4'h4, 16'h000F);
        run(10);
        // R4 hold pending while the bus is busy, overwrite while pending
        wr(4'h4, 16'h0009);
        run(5);
        bus_idle = 1'b0;
        wr(4'h4, 16'h000A);
        run(12);
        wr(4'h4, 16'h000B);
        reg_addr = 4'h4;
        run(20);
        bus_idle = 1'b1;
        run(40);
        // R4 write while an apply happens in the same cycle
        bus_idle = 1'b0;
        wr(4'h4, 16'h0008);
        bus_idle = 1'b1;
        wr(4'h4, 16'h000C);
        run(70);
        // R5 standard mode, immediate even while busy
        bus_idle = 1'b0;
        wr(4'h4, 16'h0002);
        run(10);
        wr(4'h4, 16'h000A);
        run(10);
        bus_idle = 1'b1;
        run(20);
        // R7 and R8 masks with reserved bits, power-state switching
        wr(4'h8, 16'hE07E);
        reg_addr = 4'h8; cyc();
        check("R8 reserved bits read back", reg_rdata, 16'hE07E);
        check("R8 reserved bits gated", dev_clk_en, 16'h0000);
        wr(4'h8, 16'h0A81);
        wr(4'hC, 16'h1501);
        for (int i = 0; i < 6; i++) begin
            pwr_down = i[0];
            reg_addr = i[0] ? 4'hC : 4'h8;
            cyc();
        end
        pwr_down = 1'b1; cyc();
        check("R7 power-down mask drives enables", dev_clk_en, 16'h1501);
        // R6 unmapped offsets: writes ignored, reads zero
        wr(4'h0, 16'h1234);
        wr(4'h6, 16'h0000);
        wr(4'hF, 16'h0000);
        reg_addr = 4'h0; cyc(); check("R6 unmapped read zero", reg_rdata, 16'h0000);
        reg_addr = 4'hC; cyc(); check("R6 pd mask unchanged", reg_rdata, 16'h1501);
        pwr_down = 1'b0;
        reg_addr = 4'h8; cyc(); check("R6 run mask unchanged", reg_rdata, 16'h0A81);
        reg_addr = 4'h4; cyc(); check("R6 ctrl unchanged", reg_rdata, 16'h000A);
        run(5);
        finish_up();
    end
endmodule